// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is the data path of a small 8-bit processor core, without its register file. One combinational arithmetic and logic stage takes two operands, an operation code and a bit index, and produces a result along with a preview of the next status flags. A registered 8-bit status word holds the flags that the operations read and update. Each operation owns a fixed subset of the flags and writes only those bits. For example, increment keeps the carry, nibble swap writes no flag, and the chained forms of subtract and compare carry the zero flag across the bytes of a multibyte value.

The surrounding core decodes its instructions into `op_i`. It places register or immediate values on `a_i` and `b_i`, writes `result_o` back where the instruction requires, and raises `exec_i` for each instruction that commits its flags. A branch-condition port tests any single status bit for set or clear against the registered flags. This covers the signed and unsigned comparison branches, because the sign bit is kept equal to negative XOR overflow.

Top module: `alu_flag_unit`

## Requirements
- R1: Add (code 0) and add-with-carry (code 1) return a_i + b_i (+ C for code 1), modulo 256. They update Z, C, N, V, H and S. C is the carry out of bit 7. H is the carry out of bit 3. V is signed overflow.
- R2: Subtract (code 2) and subtract-with-carry (code 3) return a_i - b_i (- C for code 3), modulo 256. C is set on a borrow out of bit 7, and H is set on a borrow into bit 4. For code 3, Z is set only when the result is zero and Z was already set.
- R3: Compare (code 18) and compare-with-carry (code 19) update the flags exactly as codes 2 and 3 do, but return a_i unchanged as the result.
- R4: AND (code 4), OR (code 5) and XOR (code 6) update only Z, N, V and S. They force V to 0 and leave C and H unchanged.
- R5: One's complement (code 7) returns 0xFF - a_i, sets C to 1 and clears V. Two's complement (code 8) returns 0x00 - a_i. It sets C when the result is nonzero, sets V when the result is 0x80, and sets H when a_i[3:0] is nonzero.
- R6: Increment (code 9) and decrement (code 10) of a_i update only Z, N, V and S, and never change C. V is set when the result is 0x80 for increment, and when it is 0x7F for decrement.
- R7: The shifts of a_i update Z, C, N, V and S, where V = N XOR the new C. The shifts are: logical left (code 11, 0 enters bit 0), logical right (code 12, 0 enters bit 7), rotate left through carry (code 13), rotate right through carry (code 14), and arithmetic right (code 15, bit 7 kept). The bit shifted out goes into C. For the rotates, the vacated bit takes the old C.
- R8: Nibble swap (code 16) exchanges a_i[3:0] with a_i[7:4]. Fill (code 17) returns 0xFF. Neither changes any flag.
- R9: Flag set (code 20) and flag clear (code 21) write the single status bit chosen by bit_sel_i. Both return a_i. The status bit order is I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R10: Bit store (code 22) copies a_i[bit_sel_i] into T. Bit load (code 23) returns a_i with bit bit_sel_i replaced by T and changes no flag.
- R11: Whenever an operation updates N or V, S becomes N XOR V.
- R12: cond_true_o is high exactly when registered status bit cond_sel_i equals cond_set_i. Testing S clear gives signed greater-or-equal. Testing C clear gives unsigned same-or-higher.
- R13: flags_o clears to 0 in reset. It loads flags_next_o at a rising clock edge only while exec_i is high, and holds otherwise.
- R14: Codes 24 to 31 return a_i and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Commit flags_next_o into the status register |
| op_i | input | 5 | Operation code |
| a_i | input | DATA_W | First operand (destination value) |
| b_i | input | DATA_W | Second operand (register or immediate) |
| bit_sel_i | input | log2(DATA_W) | Bit index for flag and T-bit operations |
| cond_sel_i | input | 3 | Status bit tested by the branch evaluator |
| cond_set_i | input | 1 | 1 tests for set, 0 tests for clear |
| result_o | output | DATA_W | Operation result |
| flags_next_o | output | 8 | Status word the current operation would commit |
| flags_o | output | 8 | Registered status word |
| cond_true_o | output | 1 | Branch condition outcome |

## Verification
A wrong ownership mask or a bad flag formula shows up at the ports in two steps. It appears in flags_next_o in the same cycle as the operation. It then persists in flags_o from the next clock edge until another operation overwrites that bit. A corrupted status bit therefore also shows in the next operation that consumes it, such as a carry-in, a chained zero or a T load, and in cond_true_o. A behavioural model steps with the design every cycle and compares result, preview, register and condition. This catches the error in the cycle it first appears, instead of after it has spread.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   localparam int NFLAGS     = 8;
   localparam int FLAG_IDX_W = 3;
   localparam int OP_W       = 5;

   // Status bit positions: index-based set/clear and branch tests rely on them
   localparam int FLG_C = 0;
   localparam int FLG_Z = 1;
   localparam int FLG_N = 2;
   localparam int FLG_V = 3;
   localparam int FLG_S = 4;
   localparam int FLG_H = 5;
   localparam int FLG_T = 6;
   localparam int FLG_I = 7;

   // Ownership masks per operation family
   localparam logic [NFLAGS-1:0] OWN_ARITH = 8'b0011_1111; // H S V N Z C
   localparam logic [NFLAGS-1:0] OWN_SHIFT = 8'b0001_1111; // S V N Z C
   localparam logic [NFLAGS-1:0] OWN_LOGIC = 8'b0001_1110; // S V N Z

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
      OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
      OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
      OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
      OP_SWAP = 5'd16, OP_FILL = 5'd17, OP_CMP  = 5'd18, OP_CPC  = 5'd19,
      OP_FSET = 5'd20, OP_FCLR = 5'd21, OP_TSTO = 5'd22, OP_TLD  = 5'd23,
      OP_PASS = 5'd24
   } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] res,
   output logic         c_out,
   output logic         h_out,
   output logic         v_out
);
   localparam int HALF = W / 2;
   localparam int MSB  = W - 1;

   logic [W:0]    full;
   logic [HALF:0] low;

   always_comb begin
      if (sub) begin
         full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
         low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
      end else begin
         full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
      end
   end

   assign res   = full[W-1:0];
   assign c_out = full[W];
   assign h_out = low[HALF];
   assign v_out = sub ? ((a[MSB] & ~b[MSB] & ~res[MSB]) | (~a[MSB] & b[MSB] & res[MSB]))
                      : ((a[MSB] &  b[MSB] & ~res[MSB]) | (~a[MSB] & ~b[MSB] & res[MSB]));

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
   import alu_flag_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         c_out
);
   localparam int HALF = W / 2;
   localparam int MSB  = W - 1;

   logic [W-1:0] swapped;

   genvar gi;
   generate
      for (gi = 0; gi < HALF; gi++) begin : g_swap
         assign swapped[gi]        = a[gi + HALF];
         assign swapped[gi + HALF] = a[gi];
      end
   endgenerate

   always_comb begin
      res   = a;
      c_out = cin;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_COM:  res = ~a;
         OP_LSL:  begin res = {a[MSB-1:0], 1'b0}; c_out = a[MSB]; end
         OP_LSR:  begin res = {1'b0, a[MSB:1]};   c_out = a[0];   end
         OP_ROL:  begin res = {a[MSB-1:0], cin};  c_out = a[MSB]; end
         OP_ROR:  begin res = {cin, a[MSB:1]};    c_out = a[0];   end
         OP_ASR:  begin res = {a[MSB], a[MSB:1]}; c_out = a[0];   end
         OP_SWAP: res = swapped;
         default: res = a;
      endcase
   end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge #(
   parameter int N = 8
) (
   input  logic [N-1:0] cur,
   input  logic [N-1:0] calc,
   input  logic [N-1:0] own,
   output logic [N-1:0] nxt
);
   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_bit
         assign nxt[gi] = own[gi] ? calc[gi] : cur[gi];
      end
   endgenerate
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval #(
   parameter int N     = 8,
   parameter int SEL_W = 3
) (
   input  logic [N-1:0]     flags,
   input  logic [SEL_W-1:0] sel,
   input  logic             want_set,
   output logic             hit
);
   assign hit = (flags[sel] == want_set);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      exec_i,
   input  logic [OP_W-1:0]           op_i,
   input  logic [DATA_W-1:0]         a_i,
   input  logic [DATA_W-1:0]         b_i,
   input  logic [$clog2(DATA_W)-1:0] bit_sel_i,
   input  logic [FLAG_IDX_W-1:0]     cond_sel_i,
   input  logic                      cond_set_i,
   output logic [DATA_W-1:0]         result_o,
   output logic [NFLAGS-1:0]         flags_next_o,
   output logic [NFLAGS-1:0]         flags_o,
   output logic                      cond_true_o
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("alu_flag_unit: DATA_W must be even and at least 8");
      end
   endgenerate

   alu_op_e                  op;
   logic [NFLAGS-1:0]        flags_q;
   logic [NFLAGS-1:0]        calc;
   logic [NFLAGS-1:0]        own;
   logic [NFLAGS-1:0]        nxt;
   logic [FLAG_IDX_W-1:0]    fidx;

   logic [DATA_W-1:0]        as_a, as_b, as_res;
   logic                     as_cin, as_sub, as_c, as_h, as_v;
   logic [DATA_W-1:0]        bo_res;
   logic                     bo_c;

   logic [DATA_W-1:0]        val, res;
   logic                     f_c, f_h, f_v, f_n, f_z, v_nc, zchain;

   assign op   = alu_op_e'(op_i);
   assign fidx = bit_sel_i[FLAG_IDX_W-1:0];

   // Adder operand selection
   always_comb begin
      as_a   = a_i;
      as_b   = b_i;
      as_cin = 1'b0;
      as_sub = 1'b0;
      case (op)
         OP_ADC:                 as_cin = flags_q[FLG_C];
         OP_SUB, OP_CMP:         as_sub = 1'b1;
         OP_SBC, OP_CPC: begin
            as_sub = 1'b1;
            as_cin = flags_q[FLG_C];
         end
         OP_NEG: begin
            as_a   = '0;
            as_b   = a_i;
            as_sub = 1'b1;
         end
         OP_INC:                 as_b = {{(DATA_W-1){1'b0}}, 1'b1};
         OP_DEC: begin
            as_b   = {{(DATA_W-1){1'b0}}, 1'b1};
            as_sub = 1'b1;
         end
         default: ;
      endcase
   end

   alu_addsub #(.W(DATA_W)) u_addsub (
      .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
      .res(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
   );

   alu_bitops #(.W(DATA_W)) u_bitops (
      .op(op), .a(a_i), .b(b_i), .cin(flags_q[FLG_C]),
      .res(bo_res), .c_out(bo_c)
   );

   // Result and candidate flags
   always_comb begin
      val    = a_i;
      res    = a_i;
      f_c    = flags_q[FLG_C];
      f_h    = flags_q[FLG_H];
      f_v    = 1'b0;
      v_nc   = 1'b0;
      zchain = 1'b0;
      own    = '0;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            val    = as_res;
            res    = as_res;
            f_c    = as_c;
            f_h    = as_h;
            f_v    = as_v;
            zchain = (op == OP_SBC);
            own    = OWN_ARITH;
         end
         OP_CMP, OP_CPC: begin
            val    = as_res;
            f_c    = as_c;
            f_h    = as_h;
            f_v    = as_v;
            zchain = (op == OP_CPC);
            own    = OWN_ARITH;
         end
         OP_AND, OP_OR, OP_XOR: begin
            val = bo_res;
            res = bo_res;
            own = OWN_LOGIC;
         end
         OP_COM: begin
            val = bo_res;
            res = bo_res;
            f_c = 1'b1;
            own = OWN_SHIFT;
         end
         OP_INC, OP_DEC: begin
            val = as_res;
            res = as_res;
            f_v = as_v;
            own = OWN_LOGIC;
         end
         OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
            val  = bo_res;
            res  = bo_res;
            f_c  = bo_c;
            v_nc = 1'b1;
            own  = OWN_SHIFT;
         end
         OP_SWAP: res = bo_res;
         OP_FILL: res = '1;
         OP_TLD:  res[bit_sel_i] = flags_q[FLG_T];
         default: ;
      endcase

      f_n = val[MSB];
      f_z = (~|val) & (~zchain | flags_q[FLG_Z]);

      calc        = flags_q;
      calc[FLG_C] = f_c;
      calc[FLG_Z] = f_z;
      calc[FLG_N] = f_n;
      calc[FLG_V] = v_nc ? (f_n ^ f_c) : f_v;
      calc[FLG_S] = f_n ^ calc[FLG_V];
      calc[FLG_H] = f_h;

      case (op)
         OP_FSET: begin calc[fidx] = 1'b1; own[fidx] = 1'b1; end
         OP_FCLR: begin calc[fidx] = 1'b0; own[fidx] = 1'b1; end
         OP_TSTO: begin calc[FLG_T] = a_i[bit_sel_i]; own[FLG_T] = 1'b1; end
         default: ;
      endcase
   end

   alu_flag_merge #(.N(NFLAGS)) u_merge (
      .cur(flags_q), .calc(calc), .own(own), .nxt(nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      flags_q <= '0;
      else if (exec_i) flags_q <= nxt;
   end

   alu_cond_eval #(.N(NFLAGS), .SEL_W(FLAG_IDX_W)) u_cond (
      .flags(flags_q), .sel(cond_sel_i), .want_set(cond_set_i), .hit(cond_true_o)
   );

   assign result_o     = res;
   assign flags_next_o = nxt;
   assign flags_o      = flags_q;

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  exec_i,
   input logic [OP_W-1:0]       op_i,
   input logic [FLAG_IDX_W-1:0] fidx_i,
   input logic [DATA_W-1:0]     a_i,
   input logic [DATA_W-1:0]     result_o,
   input logic [NFLAGS-1:0]     flags_o
);
   p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_i |=> $stable(flags_o));

   p_swap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == OP_SWAP) |=> $stable(flags_o));

   p_incdec_keep_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (op_i == OP_INC || op_i == OP_DEC))
      |=> (flags_o[FLG_C] == $past(flags_o[FLG_C])));

   p_logic_v_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
      |=> (!flags_o[FLG_V] && flags_o[FLG_C] == $past(flags_o[FLG_C])
           && flags_o[FLG_H] == $past(flags_o[FLG_H])));

   p_sign_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_INC || op_i == OP_LSR))
      |=> (flags_o[FLG_S] == (flags_o[FLG_N] ^ flags_o[FLG_V])));

   p_fset_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && op_i == OP_FSET) |=> flags_o[$past(fidx_i)]);

   p_cmp_keeps_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CMP || op_i == OP_CPC) |-> (result_o == a_i));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
   .fidx_i(bit_sel_i[2:0]), .a_i(a_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
   import alu_flag_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       exec_i;
   logic [4:0] op_i;
   logic [7:0] a_i, b_i;
   logic [2:0] bit_sel_i, cond_sel_i;
   logic       cond_set_i;
   logic [7:0] result_o, flags_next_o, flags_o;
   logic       cond_true_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] mflags;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_flag_unit u_alu_flag_unit (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .bit_sel_i(bit_sel_i),
      .cond_sel_i(cond_sel_i), .cond_set_i(cond_set_i),
      .result_o(result_o), .flags_next_o(flags_next_o),
      .flags_o(flags_o), .cond_true_o(cond_true_o)
   );

   function automatic string tag_of(input logic [4:0] op);
      case (op)
         0, 1:              return "R1";
         2, 3:              return "R2";
         18, 19:            return "R3";
         4, 5, 6:           return "R4";
         7, 8:              return "R5";
         9, 10:             return "R6";
         11, 12, 13, 14, 15: return "R7";
         16, 17:            return "R8";
         20, 21:            return "R9";
         22, 23:            return "R10";
         default:           return "R14";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: returns result and full next status word
   task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [2:0] sel, input logic [7:0] f,
                        output logic [7:0] res, output logic [7:0] nf);
      int ai, bi, ci, s;
      logic [7:0] r;
      logic c, v, h, z;
      int kind; // 0 none, 1 arith, 2 logic, 3 shift
      ai = a; bi = b; ci = 0;
      r = a; res = a; nf = f; kind = 0;
      c = f[0]; v = 1'b0; h = f[5]; z = 1'b0;
      case (op)
         0, 1: begin
            ci = (op == 1) ? int'(f[0]) : 0;
            s = ai + bi + ci; r = 8'(s); c = (s > 255);
            h = ((ai % 16) + (bi % 16) + ci) > 15;
            v = (((a ^ r) & (b ^ r)) & 8'h80) != 0;
            kind = 1; res = r;
         end
         2, 3, 18, 19: begin
            ci = (op == 3 || op == 19) ? int'(f[0]) : 0;
            s = ai - bi - ci; r = 8'(s); c = (s < 0);
            h = ((ai % 16) - (bi % 16) - ci) < 0;
            v = (((a ^ b) & (a ^ r)) & 8'h80) != 0;
            kind = 1; res = (op >= 18) ? a : r;
         end
         4: begin r = a & b; kind = 2; res = r; end
         5: begin r = a | b; kind = 2; res = r; end
         6: begin r = a ^ b; kind = 2; res = r; end
         7: begin r = 8'(255 - ai); c = 1'b1; v = 1'b0; kind = 3; res = r; end
         8: begin
            r = 8'(256 - ai); c = (r != 0); v = (r == 8'h80); h = (ai % 16) != 0;
            kind = 1; res = r;
         end
         9:  begin r = 8'(ai + 1);   v = (r == 8'h80); kind = 2; res = r; end
         10: begin r = 8'(ai + 255); v = (r == 8'h7F); kind = 2; res = r; end
         11, 12, 13, 14, 15: begin
            case (op)
               11: begin r = 8'(ai * 2);                 c = a[7]; end
               12: begin r = 8'(ai / 2);                 c = a[0]; end
               13: begin r = 8'(ai * 2 + int'(f[0]));    c = a[7]; end
               14: begin r = 8'(ai / 2 + 128 * int'(f[0])); c = a[0]; end
               default: begin r = 8'(ai / 2) | (a & 8'h80); c = a[0]; end
            endcase
            v = r[7] ^ c; kind = 3; res = r;
         end
         16: res = {a[3:0], a[7:4]};
         17: res = 8'hFF;
         20: nf[sel] = 1'b1;
         21: nf[sel] = 1'b0;
         22: nf[6] = a[sel];
         23: begin res = a; res[sel] = f[6]; end
         default: res = a;
      endcase
      if (kind != 0) begin
         z = (r == 0);
         if (op == 3 || op == 19) z = z && f[1];
         nf[1] = z; nf[2] = r[7]; nf[3] = (kind == 2 && op < 9) ? 1'b0 : v;
         nf[4] = nf[2] ^ nf[3];
         if (kind != 2) nf[0] = c;
         if (kind == 1) nf[5] = h;
      end
   endtask

   // One cycle: drive at negedge, compare combinational outputs, then the register
   task automatic step(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] sel, input bit ex,
                       input logic [2:0] csel, input logic cset);
      logic [7:0] er, ef;
      string t;
      op_i = op; a_i = a; b_i = b; bit_sel_i = sel; exec_i = ex;
      cond_sel_i = csel; cond_set_i = cset;
      #1;
      model(op, a, b, sel, mflags, er, ef);
      t = tag_of(op);
      check(result_o == er, t, "result", result_o, er);
      check(flags_next_o == ef, t, "flags_next", flags_next_o, ef);
      if (op <= 15 && op != 4'd0 + 5'd0 || op == 18 || op == 19)
         check(flags_next_o[4] == (flags_next_o[2] ^ flags_next_o[3]), "R11",
               "S=N^V", {7'd0, flags_next_o[4]}, {7'd0, flags_next_o[2] ^ flags_next_o[3]});
      check(cond_true_o == (mflags[csel] == cset), "R12", "cond",
            {7'd0, cond_true_o}, {7'd0, mflags[csel] == cset});
      @(posedge clk);
      @(negedge clk);
      if (ex) mflags = ef;
      check(flags_o == mflags, ex ? t : "R13", "flags_reg", flags_o, mflags);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R13 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; exec_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
      bit_sel_i = '0; cond_sel_i = '0; cond_set_i = 1'b0;
      mflags = 8'h00;
      repeat (3) @(negedge clk);
      check(flags_o == 8'h00, "R13", "reset flags", flags_o, 8'h00);
      rst_n = 1'b1;

      // R1: overflow and half carry, then wrap to zero, then carry-in
      step(5'd0, 8'h7F, 8'h01, 3'd0, 1, 3'd0, 1'b0);
      check(flags_o == 8'h2C, "R1", "0x7F+1 flags", flags_o, 8'h2C);
      step(5'd0, 8'h7F, 8'h01, 3'd4, 0, 3'd4, 1'b0);   // R12: signed GE after overflow
      check(cond_true_o == 1'b1, "R12", "S clear test", {7'd0, cond_true_o}, 8'h01);
      step(5'd0, 8'hFF, 8'h01, 3'd0, 1, 3'd0, 1'b1);
      step(5'd1, 8'h10, 8'h20, 3'd0, 1, 3'd0, 1'b1);
      // R2 / R3: borrow chain and zero chaining
      step(5'd2, 8'h00, 8'h01, 3'd0, 1, 3'd0, 1'b1);
      step(5'd3, 8'h05, 8'h04, 3'd0, 1, 3'd1, 1'b1);
      step(5'd2, 8'h34, 8'h34, 3'd0, 1, 3'd1, 1'b1);
      step(5'd19, 8'h12, 8'h12, 3'd0, 1, 3'd1, 1'b1);
      step(5'd18, 8'h40, 8'h41, 3'd0, 1, 3'd0, 1'b1);
      step(5'd19, 8'h00, 8'h00, 3'd0, 1, 3'd1, 1'b0);
      // R4: logic keeps C and H
      step(5'd20, 8'h00, 8'h00, 3'd5, 1, 3'd5, 1'b1);
      step(5'd4, 8'hF0, 8'h0F, 3'd0, 1, 3'd0, 1'b1);
      step(5'd5, 8'h80, 8'h01, 3'd0, 1, 3'd2, 1'b1);
      step(5'd6, 8'hAA, 8'hAA, 3'd0, 1, 3'd1, 1'b1);
      // R5 / R6
      step(5'd7, 8'h00, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      step(5'd8, 8'h80, 8'h00, 3'd0, 1, 3'd3, 1'b1);
      step(5'd8, 8'h00, 8'h00, 3'd0, 1, 3'd0, 1'b0);
      step(5'd20, 8'h00, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      step(5'd9, 8'hFF, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      check(flags_o[0] == 1'b1, "R6", "inc keeps C", flags_o, 8'h01);
      step(5'd9, 8'h7F, 8'h00, 3'd0, 1, 3'd3, 1'b1);
      step(5'd10, 8'h80, 8'h00, 3'd0, 1, 3'd3, 1'b1);
      // R7: shifts and rotates through carry
      step(5'd12, 8'h01, 8'h00, 3'd0, 1, 3'd1, 1'b1);
      step(5'd14, 8'h02, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      step(5'd13, 8'h80, 8'h00, 3'd0, 1, 3'd0, 1'b0);
      step(5'd15, 8'h81, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      step(5'd11, 8'hC0, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      // R8, R9, R10, R14
      step(5'd16, 8'h3C, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      step(5'd17, 8'h12, 8'h00, 3'd0, 1, 3'd0, 1'b1);
      for (int k = 0; k < 8; k++) step(5'd20, 8'h00, 8'h00, 3'(k), 1, 3'(k), 1'b1);
      check(flags_o == 8'hFF, "R9", "all set", flags_o, 8'hFF);
      for (int k = 0; k < 8; k++) step(5'd21, 8'h00, 8'h00, 3'(k), 1, 3'(k), 1'b0);
      step(5'd22, 8'h08, 8'h00, 3'd3, 1, 3'd6, 1'b1);
      step(5'd23, 8'h00, 8'h00, 3'd5, 1, 3'd6, 1'b1);
      step(5'd24, 8'h5A, 8'hFF, 3'd0, 1, 3'd0, 1'b0);
      step(5'd31, 8'hA5, 8'h00, 3'd0, 1, 3'd0, 1'b0);
      // R13: no commit without exec
      step(5'd0, 8'hFF, 8'hFF, 3'd0, 0, 3'd0, 1'b0);

      for (int n = 0; n < 4000; n++)
         step(5'($urandom % 32), 8'($urandom), 8'($urandom), 3'($urandom),
              bit'($urandom % 4 != 0), 3'($urandom), 1'($urandom));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule